// File: doc/BRIEF.md
# USB Device Endpoint Handshake Controller

This block keeps the configuration and transfer progress of a single USB device endpoint and picks the answer the endpoint gives to each host token. Software sets the endpoint up through a small word-wide register port. It programs the transfer type, the largest packet allowed, the starting data PID, the isochronous frame parity and three override options. It also programs the number of bytes and packets to move. Setting the enable bit then arms the endpoint.

A token port delivers one event per cycle. Each event carries the direction, the received data PID, a CRC-valid flag, the parity of the current frame and the packet length in bytes. One cycle later the block reports a handshake code, the data PID in effect, and single-cycle pulses for transfer completion and oversize packets. The remaining byte and packet counts, the enable state and the current toggle are always visible at the outputs.

When a transfer finishes, the hardware clears the enable bit. Software then reloads the counters and enables the endpoint again.

Top module: `usb_ep_resp_ctrl`

## Requirements
- R1: After reset, ep_en, data_pid, rem_bytes, rem_pkts, hs_valid, xfer_done and babble_err are all 0.
- R2: A token seen while the endpoint is not enabled or not active gives hs_valid=1 with hs_code 0 (no response), and the counters do not change.
- R3: With force-STALL (control bit 7) set on an enabled, active endpoint, every token gives hs_code 3 (STALL), ahead of all other rules, and the counters do not change.
- R4: With force-NAK (control bit 6) set and force-STALL clear, every token gives hs_code 2 (NAK), and the counters do not change.
- R5: Bulk (type 1) and interrupt (type 2) OUT data whose PID (0=DATA0, 1=DATA1) equals the expected toggle gives hs_code 1 (ACK). The toggle then flips, rem_bytes drops by the packet length and rem_pkts drops by 1.
- R6: Bulk or interrupt OUT data whose PID differs from the expected toggle gets ACK, but the counters and the toggle stay unchanged.
- R7: A bulk or interrupt IN token gives ACK with hs_pid equal to the toggle before the token, then flips the toggle and advances the counters by the sent length.
- R8: For isochronous endpoints (type 0), the handshake is always code 0. A token advances the counters only when tok_frame_odd equals the programmed parity (control bit 5). The data PID is neither checked nor changed.
- R9: OUT data with tok_crc_ok=0 is dropped (code 0, no counter change) unless snoop (control bit 8) is set, in which case it is accepted as if the CRC were good.
- R10: A write to the transfer register (address 1, bytes in bits 18:0, packets in bits 28:19) loads the counters only while ep_en is 0; while enabled the write is ignored.
- R11: A counted packet that leaves rem_pkts at 0, or that is shorter than the maximum packet size (control bits 26:16), clears ep_en and pulses xfer_done for one cycle.
- R12: OUT data longer than the maximum packet size gets code 0, pulses babble_err for one cycle and leaves the counters and toggle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control register, 1 = transfer register |
| cfg_wdata | input | 32 | Write data |
| tok_valid | input | 1 | Token event present this cycle |
| tok_dir | input | 1 | 0 = OUT, 1 = IN |
| tok_pid | input | 1 | Received data PID, 0 = DATA0, 1 = DATA1 |
| tok_crc_ok | input | 1 | Received data CRC was good |
| tok_frame_odd | input | 1 | Parity of the current frame number |
| tok_len | input | 12 | Packet length in bytes |
| hs_valid | output | 1 | Response valid, one cycle after the token |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| hs_pid | output | 1 | Toggle in effect when the token arrived |
| xfer_done | output | 1 | Transfer complete pulse |
| babble_err | output | 1 | Oversize packet pulse |
| ep_en | output | 1 | Endpoint enable state |
| data_pid | output | 1 | Current expected or transmitted PID |
| rem_bytes | output | 19 | Remaining byte count |
| rem_pkts | output | 10 | Remaining packet count |

## Verification
On every cycle the assertions check four things. Force-STALL always wins. The counters hold still while enabled unless a packet is counted. A completion pulse always comes with the enable bit cleared, and a babble pulse never comes with a handshake. Packet decrement arithmetic is also checked against the previous count. The bench scenarios alone can show the duplicate-packet retry, the IN toggle sequence, snoop acceptance of a bad CRC, the isochronous parity gating and the short-packet end of a transfer, because these depend on particular orders of tokens and exact count values.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    EP_ISO  = 2'd0,
    EP_BULK = 2'd1,
    EP_INTR = 2'd2,
    EP_RSVD = 2'd3
  } ep_type_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;

  typedef struct packed {
    logic     en;
    logic     act;
    ep_type_e typ;
    logic     tog;
    logic     odd;
    logic     nak;
    logic     stall;
    logic     snoop;
  } ep_cfg_t;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_ACT   = 1;
  localparam int CTRL_TYP   = 2;
  localparam int CTRL_PID   = 4;
  localparam int CTRL_ODD   = 5;
  localparam int CTRL_NAK   = 6;
  localparam int CTRL_STALL = 7;
  localparam int CTRL_SNOOP = 8;
  localparam int CTRL_MPS   = 16;

endpackage

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
  import usb_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MPS_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tog_flip,
  input  logic              clr_en,
  output ep_cfg_t           cfg,
  output logic [MPS_W-1:0]  mps
);

  ep_cfg_t          cfg_q, cfg_d;
  logic [MPS_W-1:0] mps_q, mps_d;

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{wdata[DATA_W-1:CTRL_MPS+MPS_W], wdata[CTRL_MPS-1:CTRL_SNOOP+1]};

  always_comb begin
    cfg_d = cfg_q;
    mps_d = mps_q;
    if (wr_ctrl) begin
      cfg_d.en    = wdata[CTRL_EN];
      cfg_d.act   = wdata[CTRL_ACT];
      cfg_d.typ   = ep_type_e'(wdata[CTRL_TYP +: 2]);
      cfg_d.tog   = wdata[CTRL_PID];
      cfg_d.odd   = wdata[CTRL_ODD];
      cfg_d.nak   = wdata[CTRL_NAK];
      cfg_d.stall = wdata[CTRL_STALL];
      cfg_d.snoop = wdata[CTRL_SNOOP];
      mps_d       = wdata[CTRL_MPS +: MPS_W];
    end
    if (tog_flip) cfg_d.tog = ~cfg_d.tog;
    if (clr_en)   cfg_d.en  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      mps_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      mps_q <= mps_d;
    end
  end

  assign cfg = cfg_q;
  assign mps = mps_q;

  // R11: completion always leaves the endpoint disabled
  assert_clr_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !cfg_q.en);

endmodule

// File: rtl/ep_xfer_cnt.sv
module ep_xfer_cnt #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 19,
  parameter int PKT_W  = 10,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_xfer,
  input  logic [DATA_W-1:0] wdata,
  input  logic              locked,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len,
  output logic [BYTE_W-1:0] bytes,
  output logic [PKT_W-1:0]  pkts
);

  localparam int PKT_LSB = BYTE_W;

  logic [BYTE_W-1:0] bytes_q, bytes_d;
  logic [PKT_W-1:0]  pkts_q, pkts_d;
  logic [BYTE_W-1:0] len_ext;

  logic unused_xfer_bits;
  assign unused_xfer_bits = ^wdata[DATA_W-1:PKT_LSB+PKT_W];

  assign len_ext = BYTE_W'(len);

  always_comb begin
    bytes_d = bytes_q;
    pkts_d  = pkts_q;
    if (adv) begin
      bytes_d = (bytes_q > len_ext) ? bytes_q - len_ext : '0;
      pkts_d  = (pkts_q != '0) ? pkts_q - 1'b1 : '0;
    end else if (wr_xfer && !locked) begin
      bytes_d = wdata[BYTE_W-1:0];
      pkts_d  = wdata[PKT_LSB +: PKT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      pkts_q  <= '0;
    end else begin
      bytes_q <= bytes_d;
      pkts_q  <= pkts_d;
    end
  end

  assign bytes = bytes_q;
  assign pkts  = pkts_q;

  // R10: counters frozen while enabled unless a packet is counted
  assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !adv) |=> ($stable(bytes_q) && $stable(pkts_q)));

  // R5: each counted packet removes exactly one packet
  assert_pkt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pkts_q != '0) |=> (pkts_q == $past(pkts_q) - 1'b1));

endmodule

// File: rtl/ep_resp_dec.sv
module ep_resp_dec
  import usb_ep_pkg::*;
#(
  parameter int MPS_W = 11,
  parameter int LEN_W = 12
) (
  input  logic             tok_valid,
  input  logic             tok_dir,
  input  logic             tok_pid,
  input  logic             tok_crc_ok,
  input  logic             tok_frame_odd,
  input  logic [LEN_W-1:0] tok_len,
  input  ep_cfg_t          cfg,
  input  logic [MPS_W-1:0] mps,
  output hs_code_e         code,
  output logic             adv,
  output logic             flip,
  output logic             babble,
  output logic             short_pkt
);

  logic is_iso, crc_pass, too_big;

  assign is_iso    = (cfg.typ == EP_ISO);
  assign crc_pass  = tok_dir || tok_crc_ok || cfg.snoop;
  assign too_big   = !tok_dir && (tok_len > LEN_W'(mps));
  assign short_pkt = (tok_len < LEN_W'(mps));

  always_comb begin
    code   = HS_NONE;
    adv    = 1'b0;
    flip   = 1'b0;
    babble = 1'b0;
    if (tok_valid && cfg.en && cfg.act) begin
      if (cfg.stall) begin
        code = HS_STALL;
      end else if (cfg.nak) begin
        code = HS_NAK;
      end else if (is_iso) begin
        if ((tok_frame_odd == cfg.odd) && crc_pass) begin
          if (too_big) babble = 1'b1;
          else         adv    = 1'b1;
        end
      end else if (crc_pass) begin
        if (too_big) begin
          babble = 1'b1;
        end else begin
          code = HS_ACK;
          if (tok_dir || (tok_pid == cfg.tog)) begin
            adv  = 1'b1;
            flip = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/usb_ep_resp_ctrl.sv
module usb_ep_resp_ctrl
  import usb_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 19,
  parameter int PKT_W  = 10,
  parameter int MPS_W  = 11,
  parameter int LEN_W  = MPS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              tok_valid,
  input  logic              tok_dir,
  input  logic              tok_pid,
  input  logic              tok_crc_ok,
  input  logic              tok_frame_odd,
  input  logic [LEN_W-1:0]  tok_len,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_pid,
  output logic              xfer_done,
  output logic              babble_err,
  output logic              ep_en,
  output logic              data_pid,
  output logic [BYTE_W-1:0] rem_bytes,
  output logic [PKT_W-1:0]  rem_pkts
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ep_cfg_t          cfg;
  logic [MPS_W-1:0] mps;
  hs_code_e         dec_code;
  logic             adv, flip, bab, short_pkt, done_now;

  ep_ctrl_reg #(.DATA_W(DATA_W), .MPS_W(MPS_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_ctrl  (cfg_we && !cfg_addr),
    .wdata    (cfg_wdata),
    .tog_flip (flip),
    .clr_en   (done_now),
    .cfg      (cfg),
    .mps      (mps)
  );

  ep_xfer_cnt #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_xfer (cfg_we && cfg_addr),
    .wdata   (cfg_wdata),
    .locked  (cfg.en),
    .adv     (adv),
    .len     (tok_len),
    .bytes   (rem_bytes),
    .pkts    (rem_pkts)
  );

  ep_resp_dec #(.MPS_W(MPS_W), .LEN_W(LEN_W)) u_dec (
    .tok_valid     (tok_valid),
    .tok_dir       (tok_dir),
    .tok_pid       (tok_pid),
    .tok_crc_ok    (tok_crc_ok),
    .tok_frame_odd (tok_frame_odd),
    .tok_len       (tok_len),
    .cfg           (cfg),
    .mps           (mps),
    .code          (dec_code),
    .adv           (adv),
    .flip          (flip),
    .babble        (bab),
    .short_pkt     (short_pkt)
  );

  assign done_now = adv && ((rem_pkts <= PKT_W'(1)) || short_pkt);

  logic       hs_valid_q, hs_valid_d;
  logic [1:0] hs_code_q, hs_code_d;
  logic       hs_pid_q, hs_pid_d;
  logic       done_q, bab_q;

  always_comb begin
    hs_valid_d = tok_valid;
    hs_code_d  = hs_code_q;
    hs_pid_d   = hs_pid_q;
    if (tok_valid) begin
      hs_code_d = dec_code;
      hs_pid_d  = cfg.tog;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      hs_valid_q <= 1'b0;
      hs_code_q  <= 2'd0;
      hs_pid_q   <= 1'b0;
      done_q     <= 1'b0;
      bab_q      <= 1'b0;
    end else begin
      hs_valid_q <= hs_valid_d;
      hs_code_q  <= hs_code_d;
      hs_pid_q   <= hs_pid_d;
      done_q     <= done_now;
      bab_q      <= bab;
    end
  end

  assign hs_valid   = hs_valid_q;
  assign hs_code    = hs_code_q;
  assign hs_pid     = hs_pid_q;
  assign xfer_done  = done_q;
  assign babble_err = bab_q;
  assign ep_en      = cfg.en;
  assign data_pid   = cfg.tog;

  // R3: force-STALL overrides every other rule
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (tok_valid && cfg.en && cfg.act && cfg.stall) |=> (hs_code_q == 2'd3));

  // R11: a completion pulse is seen with the enable already cleared
  assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done_q |-> !cfg.en);

  // R12: an oversize packet gets no handshake
  assert_babble_nohs_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bab_q |-> (hs_valid_q && hs_code_q == 2'd0));

endmodule

// File: tb/usb_ep_resp_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_resp_ctrl_tb;

  logic        clk, rst_n;
  logic        cfg_we, cfg_addr;
  logic [31:0] cfg_wdata;
  logic        tok_valid, tok_dir, tok_pid, tok_crc_ok, tok_frame_odd;
  logic [11:0] tok_len;
  logic        hs_valid, hs_pid, xfer_done, babble_err, ep_en, data_pid;
  logic [1:0]  hs_code;
  logic [18:0] rem_bytes;
  logic [9:0]  rem_pkts;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  usb_ep_resp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tok_valid(tok_valid), .tok_dir(tok_dir), .tok_pid(tok_pid), .tok_crc_ok(tok_crc_ok),
    .tok_frame_odd(tok_frame_odd), .tok_len(tok_len), .hs_valid(hs_valid), .hs_code(hs_code),
    .hs_pid(hs_pid), .xfer_done(xfer_done), .babble_err(babble_err), .ep_en(ep_en),
    .data_pid(data_pid), .rem_bytes(rem_bytes), .rem_pkts(rem_pkts)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        dir;
    logic        pid;
    logic        crc;
    logic [11:0] len;
    logic [1:0]  code;
    logic        bab;
    logic        done;
    logic [18:0] bytes;
    logic [9:0]  pkts;
    logic        tog;
    logic        hspid;
    logic        en;
  } vec_t;

  // bulk endpoint, max packet 64, 256 bytes in 4 packets, starting with DATA0
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 12'd64, 2'd1, 1'b0, 1'b0, 19'd192, 10'd3, 1'b1, 1'b0, 1'b1}, // R5
    '{1'b0, 1'b0, 1'b1, 12'd64, 2'd1, 1'b0, 1'b0, 19'd192, 10'd3, 1'b1, 1'b1, 1'b1}, // R6
    '{1'b0, 1'b1, 1'b0, 12'd64, 2'd0, 1'b0, 1'b0, 19'd192, 10'd3, 1'b1, 1'b1, 1'b1}, // R9
    '{1'b0, 1'b1, 1'b1, 12'd65, 2'd0, 1'b1, 1'b0, 19'd192, 10'd3, 1'b1, 1'b1, 1'b1}, // R12
    '{1'b1, 1'b0, 1'b1, 12'd64, 2'd1, 1'b0, 1'b0, 19'd128, 10'd2, 1'b0, 1'b1, 1'b1}, // R7
    '{1'b0, 1'b0, 1'b1, 12'd64, 2'd1, 1'b0, 1'b0, 19'd64,  10'd1, 1'b1, 1'b0, 1'b1}, // R5
    '{1'b0, 1'b1, 1'b1, 12'd64, 2'd1, 1'b0, 1'b1, 19'd0,   10'd0, 1'b0, 1'b1, 1'b0}, // R11
    '{1'b0, 1'b0, 1'b1, 12'd64, 2'd0, 1'b0, 1'b0, 19'd0,   10'd0, 1'b0, 1'b0, 1'b0}  // R2
  };

  function automatic logic [31:0] ctrl_word(input logic en, input logic act, input logic [1:0] typ,
      input logic pid, input logic odd, input logic nak, input logic stall, input logic snoop,
      input logic [10:0] mps);
    ctrl_word = {5'd0, mps, 7'd0, snoop, stall, nak, odd, pid, typ, act, en};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tok(input logic dir, input logic pid, input logic crc, input logic odd,
      input logic [11:0] len);
    @(negedge clk);
    tok_valid = 1'b1; tok_dir = dir; tok_pid = pid; tok_crc_ok = crc;
    tok_frame_odd = odd; tok_len = len;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic chk_resp(input string req, input logic [1:0] code, input logic [18:0] b,
      input logic [9:0] p);
    check(req, "hs_valid", 32'(hs_valid), 32'd1);
    check(req, "hs_code", 32'(hs_code), 32'(code));
    check(req, "rem_bytes", 32'(rem_bytes), 32'(b));
    check(req, "rem_pkts", 32'(rem_pkts), 32'(p));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
    tok_valid = 1'b0; tok_dir = 1'b0; tok_pid = 1'b0; tok_crc_ok = 1'b1;
    tok_frame_odd = 1'b0; tok_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "ep_en", 32'(ep_en), 0);
    check("R1", "data_pid", 32'(data_pid), 0);
    check("R1", "rem_bytes", 32'(rem_bytes), 0);
    check("R1", "rem_pkts", 32'(rem_pkts), 0);
    check("R1", "hs_valid", 32'(hs_valid), 0);
    check("R1", "xfer_done", 32'(xfer_done), 0);
    check("R1", "babble_err", 32'(babble_err), 0);

    // vector table: bulk transfer sequence
    wr(1'b1, {3'd0, 10'd4, 19'd256});
    wr(1'b0, ctrl_word(1, 1, 2'd1, 0, 0, 0, 0, 0, 11'd64));
    for (int i = 0; i < NV; i++) begin
      tok(VEC[i].dir, VEC[i].pid, VEC[i].crc, 1'b0, VEC[i].len);
      chk_resp($sformatf("vec%0d", i), VEC[i].code, VEC[i].bytes, VEC[i].pkts);
      check($sformatf("vec%0d", i), "babble_err", 32'(babble_err), 32'(VEC[i].bab));
      check($sformatf("vec%0d", i), "xfer_done", 32'(xfer_done), 32'(VEC[i].done));
      check($sformatf("vec%0d", i), "data_pid", 32'(data_pid), 32'(VEC[i].tog));
      check($sformatf("vec%0d", i), "hs_pid", 32'(hs_pid), 32'(VEC[i].hspid));
      check($sformatf("vec%0d", i), "ep_en", 32'(ep_en), 32'(VEC[i].en));
    end
    @(negedge clk);
    check("R11", "done pulse width", 32'(xfer_done), 0);

    // R10: load while disabled, ignored while enabled
    wr(1'b1, {3'd0, 10'd2, 19'd100});
    check("R10", "rem_bytes load", 32'(rem_bytes), 100);
    check("R10", "rem_pkts load", 32'(rem_pkts), 2);
    wr(1'b0, ctrl_word(1, 1, 2'd1, 0, 0, 0, 0, 0, 11'd64));
    wr(1'b1, {3'd0, 10'd7, 19'd500});
    check("R10", "rem_bytes locked", 32'(rem_bytes), 100);
    check("R10", "rem_pkts locked", 32'(rem_pkts), 2);

    // R3: stall wins over nak and matching data
    wr(1'b0, ctrl_word(1, 1, 2'd1, 0, 0, 1, 1, 0, 11'd64));
    tok(1'b0, 1'b0, 1'b1, 1'b0, 12'd64);
    chk_resp("R3", 2'd3, 19'd100, 10'd2);
    tok(1'b1, 1'b0, 1'b1, 1'b0, 12'd64);
    chk_resp("R3", 2'd3, 19'd100, 10'd2);

    // R4: nak
    wr(1'b0, ctrl_word(1, 1, 2'd1, 0, 0, 1, 0, 0, 11'd64));
    tok(1'b0, 1'b0, 1'b1, 1'b0, 12'd64);
    chk_resp("R4", 2'd2, 19'd100, 10'd2);
    check("R4", "data_pid", 32'(data_pid), 0);

    // R9 snoop on interrupt endpoint, short packet ends transfer (R11)
    wr(1'b0, ctrl_word(1, 1, 2'd2, 0, 0, 0, 0, 1, 11'd64));
    tok(1'b0, 1'b0, 1'b0, 1'b0, 12'd40);
    chk_resp("R9", 2'd1, 19'd60, 10'd1);
    check("R11", "short done", 32'(xfer_done), 1);
    check("R11", "short ep_en", 32'(ep_en), 0);

    // R8 isochronous parity gating
    wr(1'b1, {3'd0, 10'd3, 19'd300});
    wr(1'b0, ctrl_word(1, 1, 2'd0, 0, 1, 0, 0, 0, 11'd128));
    tok(1'b0, 1'b0, 1'b1, 1'b0, 12'd100);
    chk_resp("R8", 2'd0, 19'd300, 10'd3);
    tok(1'b0, 1'b1, 1'b1, 1'b1, 12'd128);
    chk_resp("R8", 2'd0, 19'd172, 10'd2);
    check("R8", "data_pid unchanged", 32'(data_pid), 0);
    check("R8", "no done", 32'(xfer_done), 0);
    tok(1'b0, 1'b0, 1'b1, 1'b1, 12'd44);
    chk_resp("R8", 2'd0, 19'd128, 10'd1);
    check("R11", "iso short done", 32'(xfer_done), 1);

    // R2 endpoint enabled but not active
    wr(1'b1, {3'd0, 10'd1, 19'd10});
    wr(1'b0, ctrl_word(1, 0, 2'd1, 0, 0, 0, 0, 0, 11'd64));
    tok(1'b0, 1'b0, 1'b1, 1'b0, 12'd10);
    chk_resp("R2", 2'd0, 19'd10, 10'd1);
    check("R2", "ep_en kept", 32'(ep_en), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule